// File: doc/BRIEF.md
# Page-Write Sequencer with Completion Polling

This block sits on the host side of a byte-wide, self-timed nonvolatile memory that is wired through separate active-low chip-select, read-enable and write-strobe lines plus parallel address and data buses. A client hands it one request: a start address and a byte count of 1 to 16. It then supplies the bytes on a valid/ready stream. The sequencer checks that the burst fits inside one 16-byte page. It then issues one strobed load per byte, keeping address and data steady around each strobe and starting each load well inside the memory's byte-load window.

After the final load, the sequencer waits for one full load window so that the memory has surely begun its internal programming cycle. It then reads the last written address over and over. While programming runs, the memory returns the most significant data bit inverted. The sequencer declares the write finished as soon as that bit matches the value it wrote. If no match arrives within a configurable cycle limit, it reports a timeout. Either way it releases the bus and returns to idle, so the write takes only as long as the memory actually needs rather than a fixed worst-case delay.

Top module: `pgwr_seq`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dout_en` is 0, `req_ready` is 1 and `wr_done`, `wr_timeout` and `req_reject` are 0.
- R2: A request is rejected if its length is 0, or greater than PAGE_BYTES, or if the low address bits (the offset inside the page) plus the length exceed PAGE_BYTES. A rejected request raises `req_reject` for exactly one cycle, starting the cycle after acceptance, and produces no memory strobe and no stream handshake.
- R3: `mem_we_n` is 0 only while `mem_ce_n` is 0 and `mem_oe_n` is 1. Each low pulse of `mem_we_n` lasts exactly WE_LOW_CYC cycles. `mem_addr` and `mem_dout` hold steady for at least SETUP_CYC cycles before the falling edge of `mem_we_n` and through its rising edge.
- R4: Byte i of an accepted request, taken from the stream in order, is loaded at address start+i. Every load of one request shares the same address bits above the page offset.
- R5: Within one request, successive falling edges of `mem_we_n` are at most LOAD_WIN_CYC cycles apart, provided the stream keeps `dat_valid` high.
- R6: `mem_dout_en` is never 1 while `mem_oe_n` is 0.
- R7: The first polling read, with `mem_ce_n` 0, `mem_oe_n` 0 and `mem_we_n` 1, begins no earlier than LOAD_WIN_CYC cycles after the last load ends. Each read is at the last written address. When the most significant bit of `mem_din` equals the most significant bit of the last written byte, `wr_done` pulses for one cycle and all strobes return to 1.
- R8: If no polling read matches within TMO_CYC cycles of the last load ending, `wr_timeout` pulses for one cycle instead, all strobes return to 1 and the block accepts new requests. At most one of `wr_done`, `wr_timeout` and `req_reject` is 1 in any cycle.
- R9: An accepted request takes exactly its length in bytes from the stream, one byte per load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | ADDR_W | Start address of the burst |
| req_len | input | PG_W+1 | Number of bytes, 1 to PAGE_BYTES |
| dat_valid | input | 1 | Stream byte present |
| dat_ready | output | 1 | Stream byte taken this cycle when valid |
| dat_in | input | DATA_W | Stream byte |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory read enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Data to drive onto the memory bus |
| mem_dout_en | output | 1 | Enable for the external data pad drivers |
| mem_din | input | DATA_W | Data read from the memory bus |
| wr_done | output | 1 | One-cycle pulse: write completed |
| wr_timeout | output | 1 | One-cycle pulse: polling exceeded the limit |
| req_reject | output | 1 | One-cycle pulse: request refused |

## Verification
The load-window property assumes that the stream presents the next byte as soon as `dat_ready` rises. A stalled stream would stretch the gap between strobes, and that stretch would be the stream's fault, not the sequencer's. The bench holds `dat_valid` high throughout, so the gap is set only by the sequencer's own timing.

The poll-termination checks assume that the memory model inverts the top bit only for the last loaded address and only while programming, and that it starts programming after a window of idle strobes no longer than LOAD_WIN_CYC. The bench's model is built with exactly that window. The bench runs every legal offset and length in a small page configuration, several illegal requests, and one programming time longer than the timeout limit.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_PGAP,
        ST_PREAD
    } seq_st_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pgwr_req_check.sv
module pgwr_req_check #(
    parameter int ADDR_W     = 9,
    parameter int PAGE_BYTES = 16
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [$clog2(PAGE_BYTES):0]    len,
    output logic                           ok
);
    localparam int PG_W  = $clog2(PAGE_BYTES);
    localparam int LEN_W = PG_W + 1;

    logic [LEN_W:0] span;
    logic           unused_addr;

    assign unused_addr = ^addr[ADDR_W-1:PG_W];
    assign span = {2'b00, addr[PG_W-1:0]} + {1'b0, len};
    assign ok   = (len != '0)
               && ({1'b0, len} <= (LEN_W+1)'(PAGE_BYTES))
               && (span <= (LEN_W+1)'(PAGE_BYTES));

endmodule

// File: rtl/pgwr_poll_timer.sv
module pgwr_poll_timer #(
    parameter int LIMIT = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q >= TW'(LIMIT));

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = '0;
        else if (run && !expired)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int ADDR_W       = 9,
    parameter int DATA_W       = 8,
    parameter int PAGE_BYTES   = 16,
    parameter int SETUP_CYC    = 13,
    parameter int WE_LOW_CYC   = 13,
    parameter int HOLD_CYC     = 2,
    parameter int GAP_CYC      = 2,
    parameter int ACC_CYC      = 26,
    parameter int LOAD_WIN_CYC = 2500,
    parameter int TMO_CYC      = 1250000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [$clog2(PAGE_BYTES):0]   req_len,
    input  logic                          dat_valid,
    output logic                          dat_ready,
    input  logic [DATA_W-1:0]             dat_in,
    output logic                          mem_ce_n,
    output logic                          mem_oe_n,
    output logic                          mem_we_n,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [DATA_W-1:0]             mem_dout,
    output logic                          mem_dout_en,
    input  logic [DATA_W-1:0]             mem_din,
    output logic                          wr_done,
    output logic                          wr_timeout,
    output logic                          req_reject
);
    localparam int PG_W        = $clog2(PAGE_BYTES);
    localparam int LEN_W       = PG_W + 1;
    localparam int CMAX        = imax(imax(imax(SETUP_CYC, WE_LOW_CYC), imax(HOLD_CYC, GAP_CYC)),
                                      imax(ACC_CYC, LOAD_WIN_CYC));
    localparam int CNT_W       = $clog2(CMAX + 1);
    localparam int LOAD_PERIOD = SETUP_CYC + WE_LOW_CYC + HOLD_CYC + 1;
    localparam int GW          = $clog2(LOAD_WIN_CYC + 2);

    if (LOAD_PERIOD > LOAD_WIN_CYC) begin : g_period_too_long
        $error("per-byte load period exceeds the byte-load window");
    end

    typedef struct packed {
        seq_st_e             st;
        logic                ce_n;
        logic                oe_n;
        logic                we_n;
        logic                dout_en;
        logic [ADDR_W-1:0]   addr;
        logic [ADDR_W-1:0]   base;
        logic [DATA_W-1:0]   dout;
        logic [PG_W-1:0]     idx;
        logic [LEN_W-1:0]    len;
        logic [CNT_W-1:0]    cnt;
        logic                msb;
        logic                done;
        logic                tmo;
        logic                rej;
    } seq_s;

    localparam seq_s SEQ_RST = '{st: ST_IDLE, ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, default: '0};

    seq_s d, q;
    logic req_ok, last_ld, tmr_start, tmr_run, tmr_exp;
    logic unused_din;

    assign unused_din = ^mem_din[DATA_W-2:0];

    pgwr_req_check #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
        .addr (req_addr),
        .len  (req_len),
        .ok   (req_ok)
    );

    pgwr_poll_timer #(.LIMIT(TMO_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .run     (tmr_run),
        .expired (tmr_exp)
    );

    assign last_ld = ({1'b0, q.idx} == (q.len - 1'b1));
    assign tmr_run = (q.st == ST_PGAP) || (q.st == ST_PREAD);

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.tmo     = 1'b0;
        d.rej     = 1'b0;
        dat_ready = 1'b0;
        tmr_start = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_ok) begin
                        d.st   = ST_FETCH;
                        d.ce_n = 1'b0;
                        d.base = req_addr;
                        d.len  = req_len;
                        d.idx  = '0;
                    end else begin
                        d.rej  = 1'b1;
                    end
                end
            end
            ST_FETCH: begin
                dat_ready = 1'b1;
                if (dat_valid) begin
                    d.addr    = q.base + ADDR_W'(q.idx);
                    d.dout    = dat_in;
                    d.dout_en = 1'b1;
                    d.msb     = dat_in[DATA_W-1];
                    d.cnt     = CNT_W'(SETUP_CYC - 1);
                    d.st      = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (q.cnt == '0) begin
                    d.we_n = 1'b0;
                    d.cnt  = CNT_W'(WE_LOW_CYC - 1);
                    d.st   = ST_STROBE;
                end else begin
                    d.cnt  = q.cnt - 1'b1;
                end
            end
            ST_STROBE: begin
                if (q.cnt == '0) begin
                    d.we_n = 1'b1;
                    d.cnt  = CNT_W'(HOLD_CYC - 1);
                    d.st   = ST_HOLD;
                end else begin
                    d.cnt  = q.cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (last_ld) begin
                    d.dout_en = 1'b0;
                    d.cnt     = CNT_W'(LOAD_WIN_CYC);
                    d.st      = ST_PGAP;
                    tmr_start = 1'b1;
                end else begin
                    d.idx = q.idx + 1'b1;
                    d.st  = ST_FETCH;
                end
            end
            ST_PGAP: begin
                if (q.cnt == '0) begin
                    d.oe_n = 1'b0;
                    d.cnt  = CNT_W'(ACC_CYC - 1);
                    d.st   = ST_PREAD;
                end else begin
                    d.cnt  = q.cnt - 1'b1;
                end
            end
            ST_PREAD: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    d.oe_n = 1'b1;
                    if (mem_din[DATA_W-1] == q.msb) begin
                        d.done = 1'b1;
                        d.ce_n = 1'b1;
                        d.st   = ST_IDLE;
                    end else if (tmr_exp) begin
                        d.tmo  = 1'b1;
                        d.ce_n = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.cnt  = CNT_W'(GAP_CYC - 1);
                        d.st   = ST_PGAP;
                    end
                end
            end
            default: d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign req_ready   = (q.st == ST_IDLE);
    assign mem_ce_n    = q.ce_n;
    assign mem_oe_n    = q.oe_n;
    assign mem_we_n    = q.we_n;
    assign mem_addr    = q.addr;
    assign mem_dout    = q.dout;
    assign mem_dout_en = q.dout_en;
    assign wr_done     = q.done;
    assign wr_timeout  = q.tmo;
    assign req_reject  = q.rej;

    // Observation state for the properties below
    logic [CNT_W:0] wl_cnt_q;
    logic [GW-1:0]  gap_q;
    logic           we_prev_q, armed_q, fall_now;

    assign fall_now = we_prev_q && !q.we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wl_cnt_q  <= '0;
            gap_q     <= '0;
            we_prev_q <= 1'b1;
            armed_q   <= 1'b0;
        end else begin
            we_prev_q <= q.we_n;
            if (!q.we_n && wl_cnt_q != '1) wl_cnt_q <= wl_cnt_q + 1'b1;
            else if (q.we_n)              wl_cnt_q <= '0;
            if (fall_now)                 gap_q <= GW'(1);
            else if (gap_q != '1)         gap_q <= gap_q + 1'b1;
            if (fall_now)                 armed_q <= 1'b1;
            else if (q.st == ST_PGAP)     armed_q <= 1'b0;
        end
    end

    assert_we_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));
    assert_we_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (wl_cnt_q == (CNT_W+1)'(WE_LOW_CYC)));
    assert_bus_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || $rose(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));
    assert_same_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_addr[ADDR_W-1:PG_W] == q.base[ADDR_W-1:PG_W]));
    assert_load_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_now && armed_q) |-> (gap_q <= GW'(LOAD_WIN_CYC)));
    assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> mem_oe_n);
    assert_poll_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dout_en));
    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_done, wr_timeout, req_reject}));
    assert_reject_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> (mem_ce_n && mem_we_n && req_ready));

endmodule

// File: tb/pgwr_seq_bench.sv
module pgwr_seq_bench;
    localparam int ADDR_W = 9;
    localparam int DATA_W = 8;
    localparam int PB     = 16;
    localparam int SETUP  = 2;
    localparam int WLOW   = 3;
    localparam int HOLD   = 1;
    localparam int GAP    = 1;
    localparam int ACC    = 3;
    localparam int WIN    = 16;
    localparam int TMO    = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [4:0] req_len = '0;
    logic dat_valid = 1'b1;
    logic dat_ready;
    logic [DATA_W-1:0] dat_in;
    logic mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_dout, mem_din;
    logic wr_done, wr_timeout, req_reject;

    always #4 clk = ~clk;

    pgwr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PB), .SETUP_CYC(SETUP),
               .WE_LOW_CYC(WLOW), .HOLD_CYC(HOLD), .GAP_CYC(GAP), .ACC_CYC(ACC),
               .LOAD_WIN_CYC(WIN), .TMO_CYC(TMO)) u_pgwr_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .dat_valid(dat_valid), .dat_ready(dat_ready),
        .dat_in(dat_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din),
        .wr_done(wr_done), .wr_timeout(wr_timeout), .req_reject(req_reject));

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Stream source
    logic [DATA_W-1:0] tx_data [PB];
    int hs_cnt = 0;
    int hs_base = 0;
    assign dat_in = tx_data[(hs_cnt - hs_base) & (PB-1)];
    always @(posedge clk) if (dat_ready && dat_valid) hs_cnt <= hs_cnt + 1;

    // Memory model
    logic [DATA_W-1:0] mem [512];
    logic [DATA_W-1:0] pend_d [PB];
    logic              pend_v [PB];
    logic [ADDR_W-1:0] log_a [PB];
    logic [DATA_W-1:0] log_d [PB];
    int nl = 0;
    int proto_err = 0;
    int prog_len = 50;
    bit loading = 0, programming = 0, prev_we = 1;
    int win = 0, pcnt = 0, wl = 0, stab = 0;
    logic [ADDR_W-1:0] prev_addr = '0, last_addr = '0;
    logic [DATA_W-1:0] prev_dout = '0, last_data = '0;
    logic [ADDR_W-5:0] pend_page = '0;

    always_comb begin
        if (programming && mem_addr == last_addr)
            mem_din = {~last_data[7], last_data[6:0]};
        else
            mem_din = mem[mem_addr];
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] = 8'((i * 3) ^ 8'h5A);
            for (int i = 0; i < PB; i++) pend_v[i] = 1'b0;
            loading = 0; programming = 0; prev_we = 1;
        end else begin
            if (mem_addr != prev_addr || mem_dout != prev_dout) stab = 0;
            else if (stab < 1000) stab++;
            prev_addr = mem_addr; prev_dout = mem_dout;
            if (mem_dout_en && !mem_oe_n) proto_err++;
            if (!mem_oe_n && !mem_we_n) proto_err++;
            if (!mem_we_n) wl++;
            if (prev_we && !mem_we_n) begin
                if (mem_ce_n || !mem_oe_n) proto_err++;
                if (stab < SETUP) proto_err++;
                if (programming) proto_err++;
                if (loading && mem_addr[ADDR_W-1:4] != pend_page) proto_err++;
                pend_page = mem_addr[ADDR_W-1:4];
                log_a[nl & (PB-1)] = mem_addr;
                loading = 1; win = 0;
            end else if (mem_we_n && !prev_we) begin
                if (wl != WLOW) proto_err++;
                wl = 0;
                pend_d[mem_addr[3:0]] = mem_dout; pend_v[mem_addr[3:0]] = 1'b1;
                last_addr = mem_addr; last_data = mem_dout;
                log_d[nl & (PB-1)] = mem_dout;
                nl++;
            end
            if (loading && mem_we_n && prev_we) begin
                win++;
                if (win >= WIN) begin loading = 0; programming = 1; pcnt = prog_len; end
            end else if (programming) begin
                if (pcnt == 0) begin
                    for (int i = 0; i < PB; i++)
                        if (pend_v[i]) begin mem[{pend_page, 4'(i)}] = pend_d[i]; pend_v[i] = 1'b0; end
                    programming = 0;
                end else pcnt--;
            end
            prev_we = mem_we_n;
        end
    end

    task automatic run_tx(input int base, input int len, input int plen, input bit exp_tmo);
        int nb, hb, pe, res, pg;
        logic [DATA_W-1:0] snap [PB];
        pg = base & ~(PB-1);
        for (int i = 0; i < PB; i++) begin
            tx_data[i] = 8'((base * 5 + i * 37 + len * 11 + 3) & 255);
            snap[i] = mem[pg + i];
        end
        prog_len = plen;
        @(negedge clk);
        nb = nl; hb = hs_cnt; hs_base = hs_cnt; pe = proto_err;
        req_addr = ADDR_W'(base); req_len = 5'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        res = 0;
        for (int t = 0; t < 3000 && res == 0; t++) begin
            if (wr_done) res = 1;
            else if (wr_timeout) res = 2;
            else if (req_reject) res = 3;
            else @(negedge clk);
        end
        chk(res == (exp_tmo ? 2 : 1), exp_tmo ? "R8 outcome" : "R7 outcome", res, exp_tmo ? 2 : 1);
        chk(hs_cnt - hb == len, "R9 bytes taken", hs_cnt - hb, len);
        chk(proto_err == pe, "R3 R5 R6 strobe protocol", proto_err - pe, 0);
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && req_ready, "R7 R8 bus released",
            {mem_ce_n, mem_oe_n, mem_we_n, req_ready}, 15);
        chk(nl - nb == len, "R4 load count", nl - nb, len);
        for (int i = 0; i < len; i++)
            if (log_a[(nb + i) & (PB-1)] != ADDR_W'(base + i) || log_d[(nb + i) & (PB-1)] != tx_data[i])
                chk(0, "R4 load order", int'(log_a[(nb + i) & (PB-1)]), base + i);
        if (exp_tmo) begin
            repeat (plen + 50) @(negedge clk);
        end else begin
            chk(!programming, "R7 done after programming", int'(programming), 0);
            for (int j = 0; j < PB; j++) begin
                if (j + pg >= base && j + pg < base + len) begin
                    if (mem[pg + j] != tx_data[j + pg - base])
                        chk(0, "R4 written byte", int'(mem[pg + j]), int'(tx_data[j + pg - base]));
                end else if (mem[pg + j] != snap[j])
                    chk(0, "R4 neighbour untouched", int'(mem[pg + j]), int'(snap[j]));
            end
        end
    endtask

    task automatic run_rej(input int base, input int len);
        int nb, hb;
        bit seen;
        @(negedge clk);
        nb = nl; hb = hs_cnt;
        req_addr = ADDR_W'(base); req_len = 5'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_reject == 1'b1, "R2 reject pulse", int'(req_reject), 1);
        @(negedge clk);
        chk(req_reject == 1'b0, "R2 reject one cycle", int'(req_reject), 0);
        seen = 0;
        for (int t = 0; t < 20; t++) begin
            if (!mem_ce_n || !mem_we_n) seen = 1;
            @(negedge clk);
        end
        chk(!seen && nl == nb && hs_cnt == hb, "R2 no strobe", int'(seen) + nl - nb + hs_cnt - hb, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dout_en && req_ready &&
            !wr_done && !wr_timeout && !req_reject, "R1 reset outputs",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en, req_ready}, 29);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(mem_ce_n && req_ready && !wr_done, "R1 idle after reset", int'(mem_ce_n), 1);
        run_rej(0, 0);
        run_rej(32, 17);
        run_rej(10, 7);
        run_rej(15, 2);
        for (int off = 0; off < PB; off++)
            for (int len = 1; len <= PB - off; len++)
                run_tx(((off * 16 + len) % 32) * PB + off, len, 20 + ((off * 16 + len) * 13) % 120, 1'b0);
        run_tx(3 * PB + 4, 5, 400, 1'b1);
        run_tx(7 * PB, 16, 0, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=190000 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule